// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block decides, while a branch sits in the decode stage of a five-stage pipeline, whether the fetch unit must leave its sequential path. Every branch condition looks at one source register and compares it with zero. The block takes that register's value after forwarding, the sign-extended 16-bit displacement and the incremented PC that fetch passed along. It returns a select for the next PC, the branch target and, where the mode needs one, a kill for the instruction held in the IF/ID latch. A dedicated adder forms the target, and the zero tests are simple. This lets a taken branch cost one cycle rather than three.

The `delay_mode_i` input chooses between two ways of handling the instruction fetched behind the branch. With `delay_mode_i` low, that successor is predicted not taken and is killed when the branch is taken. With `delay_mode_i` high, that successor is an architectural delay slot: it always completes, and the fetch after it comes from the target. A branch that needs a register still being loaded by the instruction in EX is held in decode for one cycle before it is evaluated.

Top module: `branch_resolve`

## Requirements
- R1: Kind code 1 (equal-zero) redirects when every bit of `src_val_i` is zero, and does not redirect otherwise.
- R2: Kind code 2 (nonzero) redirects when any bit of `src_val_i` is set.
- R3: Kind code 3 (negative) redirects when the top bit of `src_val_i` is 1. Kind code 4 (non-negative) redirects when it is 0. No other bit affects either result.
- R4: `target_o` always equals `npc_i` plus `offset_i` sign-extended to the PC width, taken modulo 2^PC_W.
- R5: Kind code 5 (jump) redirects whatever the register value and load state. Kind codes 0, 6 and 7 never redirect.
- R6: With `delay_mode_i` = 0, a taken branch raises `pc_sel_o` and `squash_o` in the same cycle. A branch that is not taken raises neither.
- R7: With `delay_mode_i` = 1, a taken branch raises `pc_sel_o` while `squash_o` stays low, so the fetched successor completes.
- R8: If `ex_load_i` = 1 and `ex_dst_i` equals `src_idx_i` for a kind 1 to 4 branch, `stall_o` is raised and `pc_sel_o` and `squash_o` stay low. A jump never stalls.
- R9: In delay mode, the first valid instruction after an accepted branch of kind 1 to 5 is its slot. A branch in that slot neither redirects nor stalls. Invalid cycles between the branch and the slot do not count as the slot.
- R10: Reset forgets a pending delay slot, so the first branch after reset acts normally.
- R11: While `id_valid_i` = 0, `pc_sel_o`, `squash_o` and `stall_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| delay_mode_i | input | 1 | 0: predict not taken with kill; 1: one delay slot |
| id_valid_i | input | 1 | Decode stage holds a valid instruction |
| br_kind_i | input | 3 | Branch kind code (see R1 to R5) |
| src_idx_i | input | RIDX_W | Index of the tested register |
| src_val_i | input | XLEN | Tested register value after forwarding |
| offset_i | input | OFF_W | Displacement from the instruction |
| npc_i | input | PC_W | Incremented PC from fetch |
| ex_load_i | input | 1 | Instruction in EX is a load |
| ex_dst_i | input | RIDX_W | Destination index of the instruction in EX |
| pc_sel_o | output | 1 | Fetch from `target_o` next |
| target_o | output | PC_W | Branch target |
| squash_o | output | 1 | Turn the IF/ID contents into a no-op |
| stall_o | output | 1 | Hold PC and IF/ID this cycle |

## Verification
The bench builds the block with XLEN = 16, PC_W = 20 and NREGS = 8. With a narrow register, single-bit patterns can be placed at both ends of the value, which tests the nonzero OR tree and the sign-only rule. With a 20-bit PC, target wraparound at both ends of the address space can be reached with small offsets. An index width of 3 keeps matches between `ex_dst_i` and `src_idx_i` frequent during the randomized run. That run also mixes both modes with bubbles, so delay-slot tracking across invalid cycles comes up often.

// File: rtl/branch_resolve_pkg.sv
package branch_resolve_pkg;
  typedef enum logic [2:0] {
    BK_NONE = 3'd0,
    BK_EQZ  = 3'd1,
    BK_NEZ  = 3'd2,
    BK_LTZ  = 3'd3,
    BK_GEZ  = 3'd4,
    BK_JMP  = 3'd5
  } br_kind_e;
endpackage

// File: rtl/br_cond.sv
module br_cond #(
  parameter int XLEN = 32
) (
  input  logic [2:0]      kind_i,
  input  logic [XLEN-1:0] src_i,
  output logic            take_o,
  output logic            uses_src_o,
  output logic            is_br_o
);
  import branch_resolve_pkg::*;
  br_kind_e kind;
  logic nz, neg;
  assign kind = br_kind_e'(kind_i);
  assign nz   = |src_i;
  assign neg  = src_i[XLEN-1];

  always_comb begin
    take_o     = 1'b0;
    uses_src_o = 1'b0;
    is_br_o    = 1'b1;
    unique case (kind)
      BK_EQZ: begin take_o = ~nz;  uses_src_o = 1'b1; end
      BK_NEZ: begin take_o = nz;   uses_src_o = 1'b1; end
      BK_LTZ: begin take_o = neg;  uses_src_o = 1'b1; end
      BK_GEZ: begin take_o = ~neg; uses_src_o = 1'b1; end
      BK_JMP: take_o = 1'b1;
      default: is_br_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  npc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [PC_W-1:0]  target_o
);
  localparam int EXT_W = PC_W - OFF_W;
  logic [PC_W-1:0] off_ext;
  generate
    if (EXT_W > 0) begin : g_ext
      assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
    end else begin : g_trunc
      assign off_ext = off_i[PC_W-1:0];
    end
  endgenerate
  assign target_o = npc_i + off_ext;
endmodule

// File: rtl/br_hazard.sv
module br_hazard #(
  parameter int RIDX_W = 5
) (
  input  logic              need_i,
  input  logic              ex_load_i,
  input  logic [RIDX_W-1:0] ex_dst_i,
  input  logic [RIDX_W-1:0] src_idx_i,
  output logic              stall_o
);
  assign stall_o = need_i & ex_load_i & (ex_dst_i == src_idx_i);
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int XLEN  = 32,
  parameter int PC_W  = 32,
  parameter int OFF_W = 16,
  parameter int NREGS = 32,
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              delay_mode_i,
  input  logic              id_valid_i,
  input  logic [2:0]        br_kind_i,
  input  logic [RIDX_W-1:0] src_idx_i,
  input  logic [XLEN-1:0]   src_val_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [PC_W-1:0]   npc_i,
  input  logic              ex_load_i,
  input  logic [RIDX_W-1:0] ex_dst_i,
  output logic              pc_sel_o,
  output logic [PC_W-1:0]   target_o,
  output logic              squash_o,
  output logic              stall_o
);
  logic take, uses_src, is_br;
  logic slot_q, slot_d;
  logic live, hz, accept;

  br_cond #(.XLEN(XLEN)) u_cond (
    .kind_i    (br_kind_i),
    .src_i     (src_val_i),
    .take_o    (take),
    .uses_src_o(uses_src),
    .is_br_o   (is_br)
  );

  br_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .npc_i   (npc_i),
    .off_i   (offset_i),
    .target_o(target_o)
  );

  // a branch sitting in a delay slot is inert
  assign live = id_valid_i & ~slot_q;

  br_hazard #(.RIDX_W(RIDX_W)) u_hz (
    .need_i   (live & uses_src),
    .ex_load_i(ex_load_i),
    .ex_dst_i (ex_dst_i),
    .src_idx_i(src_idx_i),
    .stall_o  (hz)
  );

  assign accept   = live & ~hz;
  assign stall_o  = hz;
  assign pc_sel_o = accept & take;
  assign squash_o = accept & take & ~delay_mode_i;

  always_comb begin
    slot_d = slot_q;
    if (id_valid_i && !hz) slot_d = accept & is_br & delay_mode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slot_q <= 1'b0;
    else         slot_q <= slot_d;
  end
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       delay_mode_i,
  input logic       id_valid_i,
  input logic [2:0] br_kind_i,
  input logic       pc_sel_o,
  input logic       squash_o,
  input logic       stall_o,
  input logic       slot_q
);
  a_r6_squash_with_redirect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    squash_o |-> (pc_sel_o && !delay_mode_i));
  a_r7_slot_mode_no_kill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    delay_mode_i |-> !squash_o);
  a_r8_stall_holds_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (!pc_sel_o && !squash_o));
  a_r5_jump_redirects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_valid_i && br_kind_i == 3'd5 && !slot_q) |-> pc_sel_o);
  a_r9_slot_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q && id_valid_i) |-> (!pc_sel_o && !stall_o));
  a_r9_slot_follows_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_sel_o && delay_mode_i) |=> slot_q);
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !id_valid_i |-> (!pc_sel_o && !stall_o && !squash_o));
endmodule

bind branch_resolve branch_resolve_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .delay_mode_i(delay_mode_i),
  .id_valid_i  (id_valid_i),
  .br_kind_i   (br_kind_i),
  .pc_sel_o    (pc_sel_o),
  .squash_o    (squash_o),
  .stall_o     (stall_o),
  .slot_q      (slot_q)
);

// File: tb/branch_resolve_test.sv
module branch_resolve_test;
  localparam int CLK_P = 10;
  localparam int XL = 16;
  localparam int PW = 20;
  localparam int NR = 8;
  localparam int RW = $clog2(NR);

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode = 1'b0, valid = 1'b0, ld = 1'b0;
  logic [2:0] kind = 3'd0;
  logic [RW-1:0] sidx = '0, dst = '0;
  logic [XL-1:0] src = '0;
  logic [15:0] off = '0;
  logic [PW-1:0] npc = '0;
  logic pc_sel, squash, stall;
  logic [PW-1:0] target;

  int checks = 0, fails = 0;
  bit m_slot = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  branch_resolve #(.XLEN(XL), .PC_W(PW), .OFF_W(16), .NREGS(NR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .delay_mode_i(mode), .id_valid_i(valid),
    .br_kind_i(kind), .src_idx_i(sidx), .src_val_i(src), .offset_i(off),
    .npc_i(npc), .ex_load_i(ld), .ex_dst_i(dst),
    .pc_sel_o(pc_sel), .target_o(target), .squash_o(squash), .stall_o(stall));

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0; m_slot = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one cycle: drive, compare against the behavioural model, advance model
  task automatic step(input bit m, input bit v, input int k, input logic [XL-1:0] s,
                      input logic [15:0] o, input logic [PW-1:0] n, input bit l,
                      input int d, input int si, input string tag);
    bit cond, uses, e_stall, e_sel, e_sq, isbr;
    logic [PW-1:0] e_tgt;
    int signed so;
    @(negedge clk);
    mode = m; valid = v; kind = 3'(k); src = s; off = o; npc = n;
    ld = l; dst = RW'(d); sidx = RW'(si);
    #(CLK_P/4);
    uses = (k >= 1 && k <= 4);
    isbr = (k >= 1 && k <= 5);
    case (k)
      1: cond = (s == 0);
      2: cond = (s != 0);
      3: cond = s[XL-1];
      4: cond = !s[XL-1];
      5: cond = 1'b1;
      default: cond = 1'b0;
    endcase
    e_stall = v && !m_slot && uses && l && (d == si);
    e_sel = v && !m_slot && !e_stall && cond;
    e_sq = e_sel && !m;
    so = $signed(o);
    e_tgt = PW'(int'(n) + so);
    checks++;
    if (pc_sel !== e_sel || squash !== e_sq || stall !== e_stall || target !== e_tgt) begin
      fails++;
      $display("FAIL %s: got sel=%b sq=%b st=%b tgt=%h, expected sel=%b sq=%b st=%b tgt=%h",
               tag, pc_sel, squash, stall, target, e_sel, e_sq, e_stall, e_tgt);
    end
    if (v && !e_stall) m_slot = m && isbr && !m_slot;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: got running, expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R11 / R10: idle after reset
    step(0, 0, 1, 0, 16'h0010, 20'h00100, 0, 0, 1, "R11 idle after reset");
    // R1
    step(0, 1, 1, 16'h0000, 16'h0010, 20'h00100, 0, 0, 1, "R1 eqz zero");
    step(0, 1, 1, 16'h8000, 16'h0010, 20'h00100, 0, 0, 1, "R1 eqz msb set");
    // R2
    step(0, 1, 2, 16'h0001, 16'h0020, 20'h00200, 0, 0, 2, "R2 nez lsb");
    step(0, 1, 2, 16'h8000, 16'h0020, 20'h00200, 0, 0, 2, "R2 nez msb");
    step(0, 1, 2, 16'h0000, 16'h0020, 20'h00200, 0, 0, 2, "R2 nez zero");
    // R3
    step(0, 1, 3, 16'h8000, 16'h0004, 20'h00300, 0, 0, 3, "R3 ltz neg");
    step(0, 1, 3, 16'h7FFF, 16'h0004, 20'h00300, 0, 0, 3, "R3 ltz pos");
    step(0, 1, 4, 16'h7FFF, 16'h0004, 20'h00300, 0, 0, 3, "R3 gez pos");
    step(0, 1, 4, 16'hFFFF, 16'h0004, 20'h00300, 0, 0, 3, "R3 gez neg");
    // R4 wraparound both ways
    step(0, 0, 0, 0, 16'hFFF0, 20'h00004, 0, 0, 0, "R4 wrap low");
    step(0, 0, 0, 0, 16'h0010, 20'hFFFF8, 0, 0, 0, "R4 wrap high");
    step(0, 0, 0, 0, 16'h8000, 20'h10000, 0, 0, 0, "R4 min offset");
    // R5
    step(0, 1, 5, 16'h1234, 16'h0040, 20'h00400, 1, 2, 2, "R5 jump under load");
    step(0, 1, 6, 16'h0000, 16'h0040, 20'h00400, 0, 0, 0, "R5 code 6 inert");
    step(0, 1, 0, 16'h0000, 16'h0040, 20'h00400, 0, 0, 0, "R5 code 0 inert");
    // R6 / R7
    step(0, 1, 1, 16'h0000, 16'h0008, 20'h00500, 0, 0, 4, "R6 squash on taken");
    step(1, 1, 1, 16'h0000, 16'h0008, 20'h00500, 0, 0, 4, "R7 taken no squash");
    step(1, 1, 0, 16'h0000, 16'h0008, 20'h00504, 0, 0, 4, "R7 slot plain op");
    // R8
    step(0, 1, 2, 16'h0001, 16'h0008, 20'h00600, 1, 3, 3, "R8 load-use stall");
    step(0, 1, 2, 16'h0001, 16'h0008, 20'h00600, 0, 3, 3, "R8 after stall");
    step(0, 1, 2, 16'h0001, 16'h0008, 20'h00600, 1, 4, 3, "R8 other dst");
    // R9: slot branch inert, bubble does not consume slot
    step(1, 1, 5, 0, 16'h0100, 20'h00700, 0, 0, 0, "R9 first jump");
    step(1, 0, 5, 0, 16'h0100, 20'h00704, 0, 0, 0, "R9 bubble");
    step(1, 1, 1, 0, 16'h0100, 20'h00704, 1, 1, 1, "R9 slot branch inert");
    step(1, 1, 1, 0, 16'h0100, 20'h00800, 0, 0, 1, "R9 after slot acts");
    // R10: reset drops pending slot
    step(1, 1, 5, 0, 16'h0100, 20'h00900, 0, 0, 0, "R10 jump before reset");
    do_reset();
    step(1, 1, 5, 0, 16'h0100, 20'h00A00, 0, 0, 0, "R10 first after reset");
    for (int i = 0; i < 400; i++) begin
      step(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 3) != 0),
           int'($urandom_range(0, 7)), XL'($urandom() & ((i % 3 == 0) ? 32'h8001 : 32'hFFFF)),
           16'($urandom()), PW'($urandom()), bit'($urandom_range(0, 1)),
           int'($urandom_range(0, NR - 1)), int'($urandom_range(0, NR - 1)),
           "R1-mix random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule